// File: doc/BRIEF.md
# Sum-of-Products Logic Core with Pin-Controlled Hold Mode

This block is a small programmable sum-of-products logic core with a low-power hold mode driven by a single pin. Each macrocell ORs several product terms. It then either passes the sum straight through or takes it from a register, and applies an optional inversion. A separate product term drives the macrocell's output enable. The array sees four groups of signals: the input pins, the dual-use power-down pin, the register feedback and the I/O pin levels.

A configuration bit sets the role of the power-down pin. When the bit is clear, the pin is one more array input. When the bit is set, the pin no longer reaches the array. Instead, a high level on it freezes the block: the outputs and output enables hold the values they had when the hold began, no register or keeper changes, and no other input can affect the block. Every input and I/O pin has a keeper. An undriven pin presents its last driven level to the array.

Top module: `pd_hold_pld`

## Requirements
- R1: The array vector is {io pin levels, register feedback, power-down term, input pin levels}, with input pin k at bit k, the power-down term at bit NI, register q[m] at bit NI+1+m and I/O pin level m at bit NI+1+NM+m. A product term is true when every bit set in its true mask is 1 and every bit set in its complement mask is 0. The sum of macrocell m is the OR of its NP terms. Term p of macrocell m uses mask slice (m*NP+p)*AW. The output enable of macrocell m is its own term at slice m*AW.
- R2: A macrocell with its register bit set outputs its register. The register loads the macrocell sum at each clock edge. The inversion bit XORs the selected value.
- R3: While rst_n is low, all registers, keepers, the snapshot and the hold state are cleared.
- R4: With the enable bit clear, the power-down pin is array bit NI and hold is never entered.
- R5: With the enable bit set, array bit NI reads 0 whatever the pin level.
- R6: Hold begins at the first clock edge where the enable bit and the pin are both high. From that edge on, mc_out and mc_oe keep their pre-edge values, including a disabled output enable, whatever happens on the inputs.
- R7: No register changes at the entry edge or during hold. After exit, the registered outputs continue from the values held before entry.
- R8: Hold ends at the EXIT_CYC-th clock edge (default 3) at which the pin is sampled low. A high sample during the countdown restarts it.
- R9: An undriven input or I/O pin presents its last driven level to the array. A macrocell whose output enable is set counts as driving its I/O pin. Keepers do not change during hold, even if pins are driven then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| in_pins | input | NI | Input pin values |
| in_drv | input | NI | Input pin actively driven |
| pd_pin | input | 1 | Power-down pin / array input |
| pd_en | input | 1 | Power-down feature enable |
| io_ext | input | NM | Value driven onto I/O pins from outside |
| io_drv | input | NM | I/O pin externally driven |
| cfg_tmask | input | NM*NP*AW | Product term true masks |
| cfg_cmask | input | NM*NP*AW | Product term complement masks |
| cfg_oe_t | input | NM*AW | Output-enable term true masks |
| cfg_oe_c | input | NM*AW | Output-enable term complement masks |
| cfg_reg | input | NM | Registered output select |
| cfg_inv | input | NM | Output inversion |
| mc_out | output | NM | Macrocell output values |
| mc_oe | output | NM | Macrocell output enables |

## Verification
The combinational path is swept over all 128 combinations of input pins, the power-down pin and the I/O levels with the feature disabled. This shows whether the pin acts as an array input. A second sweep raises the pin mid-cycle with the feature enabled, which shows that the pin is cut off from the array before hold takes effect. During hold the inputs, I/O levels and drivers are changed each cycle. The outputs must stay frozen, and a disabled output enable must stay disabled. Exit is checked edge by edge, including a countdown that is restarted partway. Drive patterns applied before and during hold are then released, which tells apart keepers that track every drive from keepers that freeze while held.

// File: rtl/pd_hold_pld.sv
module pd_hold_pld #(
  parameter int NI = 4,
  parameter int NM = 2,
  parameter int NP = 2,
  parameter int EXIT_CYC = 3
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NI-1:0]                 in_pins,
  input  logic [NI-1:0]                 in_drv,
  input  logic                          pd_pin,
  input  logic                          pd_en,
  input  logic [NM-1:0]                 io_ext,
  input  logic [NM-1:0]                 io_drv,
  input  logic [NM*NP*(NI+1+2*NM)-1:0]  cfg_tmask,
  input  logic [NM*NP*(NI+1+2*NM)-1:0]  cfg_cmask,
  input  logic [NM*(NI+1+2*NM)-1:0]     cfg_oe_t,
  input  logic [NM*(NI+1+2*NM)-1:0]     cfg_oe_c,
  input  logic [NM-1:0]                 cfg_reg,
  input  logic [NM-1:0]                 cfg_inv,
  output logic [NM-1:0]                 mc_out,
  output logic [NM-1:0]                 mc_oe
);
  localparam int AW = NI + 1 + 2*NM;
  localparam int CW = $clog2(EXIT_CYC + 1);

  logic          hold_q;
  logic [CW-1:0] cnt_q;
  logic [NM-1:0] q_r, kio_r, snap_out, snap_oe;
  logic [NM-1:0] sum, oe_live, out_live, io_lvl;
  logic [NI-1:0] kin_r, in_lvl;
  logic [AW-1:0] arr;

  wire pd_req = pd_en & pd_pin;
  wire frz    = hold_q | pd_req;

  assign in_lvl = (in_drv & in_pins) | (~in_drv & kin_r);
  assign io_lvl = (io_drv & io_ext) | (~io_drv & kio_r);
  assign arr    = {io_lvl, q_r, pd_pin & ~pd_en, in_lvl};

  function automatic logic pterm(input logic [AW-1:0] t, input logic [AW-1:0] c,
                                 input logic [AW-1:0] a);
    return &((~t | a) & (~c | ~a));
  endfunction

  for (genvar m = 0; m < NM; m++) begin : g_mc
    logic [NP-1:0] pt;
    for (genvar p = 0; p < NP; p++) begin : g_pt
      assign pt[p] = pterm(cfg_tmask[(m*NP+p)*AW +: AW], cfg_cmask[(m*NP+p)*AW +: AW], arr);
    end
    assign sum[m]      = |pt;
    assign oe_live[m]  = pterm(cfg_oe_t[m*AW +: AW], cfg_oe_c[m*AW +: AW], arr);
    assign out_live[m] = (cfg_reg[m] ? q_r[m] : sum[m]) ^ cfg_inv[m];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pd_req) begin
      hold_q <= 1'b1;
      cnt_q  <= CW'(EXIT_CYC);
    end else if (hold_q) begin
      if (cnt_q == CW'(1)) hold_q <= 1'b0;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_out <= '0;
      snap_oe  <= '0;
    end else if (pd_req && !hold_q) begin
      snap_out <= out_live;
      snap_oe  <= oe_live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      kin_r <= '0;
      kio_r <= '0;
    end else if (!frz) begin
      q_r   <= sum;
      kin_r <= in_lvl;
      kio_r <= (oe_live & out_live) | (~oe_live & io_lvl);
    end
  end

  assign mc_out = hold_q ? snap_out : out_live;
  assign mc_oe  = hold_q ? snap_oe  : oe_live;
endmodule

// File: rtl/pd_hold_pld_chk.sv
module pd_hold_pld_chk #(
  parameter int NI = 4,
  parameter int NM = 2
)(
  input logic          clk,
  input logic          rst_n,
  input logic          pd_pin,
  input logic          pd_en,
  input logic          hold,
  input logic [NM-1:0] mc_out,
  input logic [NM-1:0] mc_oe,
  input logic [NM-1:0] q,
  input logic [NM-1:0] kio,
  input logic [NI-1:0] kin
);
  // R6
  entry_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en && pd_pin) |=> ($stable(mc_out) && $stable(mc_oe)));

  // R6
  held_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!hold || ($stable(mc_out) && $stable(mc_oe))));

  // R7
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold || (pd_en && pd_pin)) |=> $stable(q));

  // R9
  keeper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold || (pd_en && pd_pin)) |=> ($stable(kin) && $stable(kio)));

  // R4
  no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_en |=> !$rose(hold));
endmodule

bind pd_hold_pld pd_hold_pld_chk #(.NI(NI), .NM(NM)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .pd_en(pd_en), .hold(hold_q),
  .mc_out(mc_out), .mc_oe(mc_oe), .q(q_r), .kio(kio_r), .kin(kin_r));

// File: tb/pd_hold_pld_tb.sv
module pd_hold_pld_tb;
  localparam int NI = 4, NM = 2, NP = 2, EXIT_CYC = 3;
  localparam int AW = NI + 1 + 2*NM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] in_pins = '0, in_drv = '0;
  logic pd_pin = 1'b0, pd_en = 1'b0;
  logic [NM-1:0] io_ext = '0, io_drv = '0;
  logic [NM*NP*AW-1:0] cfg_tmask, cfg_cmask;
  logic [NM*AW-1:0] cfg_oe_t, cfg_oe_c;
  logic [NM-1:0] cfg_reg = '0, cfg_inv = 2'b01;
  logic [NM-1:0] mc_out, mc_oe;

  int n_chk = 0, n_fail = 0;
  logic [NM-1:0] m_q = '0, m_kio = '0, m_so = '0, m_soe = '0;
  logic [NI-1:0] m_kin = '0;
  logic m_hold = 1'b0;
  int m_low = 0;

  always #5 clk = ~clk;

  pd_hold_pld #(.NI(NI), .NM(NM), .NP(NP), .EXIT_CYC(EXIT_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_pins(in_pins), .in_drv(in_drv), .pd_pin(pd_pin),
    .pd_en(pd_en), .io_ext(io_ext), .io_drv(io_drv), .cfg_tmask(cfg_tmask),
    .cfg_cmask(cfg_cmask), .cfg_oe_t(cfg_oe_t), .cfg_oe_c(cfg_oe_c),
    .cfg_reg(cfg_reg), .cfg_inv(cfg_inv), .mc_out(mc_out), .mc_oe(mc_oe));

  function automatic logic pt(input logic [AW-1:0] t, input logic [AW-1:0] c,
                              input logic [AW-1:0] a);
    logic r = 1'b1;
    for (int k = 0; k < AW; k++) begin
      if (t[k] && !a[k]) r = 1'b0;
      if (c[k] && a[k])  r = 1'b0;
    end
    return r;
  endfunction

  task automatic live(output logic [NM-1:0] o, output logic [NM-1:0] e,
                      output logic [NM-1:0] s);
    logic [AW-1:0] a;
    for (int k = 0; k < NI; k++) a[k] = in_drv[k] ? in_pins[k] : m_kin[k];
    a[NI] = pd_en ? 1'b0 : pd_pin;
    for (int j = 0; j < NM; j++) begin
      a[NI+1+j]    = m_q[j];
      a[NI+1+NM+j] = io_drv[j] ? io_ext[j] : m_kio[j];
    end
    for (int m = 0; m < NM; m++) begin
      s[m] = 1'b0;
      for (int p = 0; p < NP; p++)
        if (pt(cfg_tmask[(m*NP+p)*AW +: AW], cfg_cmask[(m*NP+p)*AW +: AW], a)) s[m] = 1'b1;
      e[m] = pt(cfg_oe_t[m*AW +: AW], cfg_oe_c[m*AW +: AW], a);
      o[m] = (cfg_reg[m] ? m_q[m] : s[m]) ^ cfg_inv[m];
    end
  endtask

  task automatic check(input string tag);
    logic [NM-1:0] o, e, s, eo, ee;
    #1;
    live(o, e, s);
    eo = m_hold ? m_so : o;
    ee = m_hold ? m_soe : e;
    n_chk++;
    if (mc_out !== eo || mc_oe !== ee) begin
      n_fail++;
      $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b", tag, mc_out, mc_oe, eo, ee);
    end
  endtask

  task automatic step();
    logic [NM-1:0] o, e, s;
    logic req;
    live(o, e, s);
    req = pd_en && pd_pin;
    @(posedge clk);
    if (!m_hold && !req) begin
      m_q = s;
      for (int k = 0; k < NI; k++) if (in_drv[k]) m_kin[k] = in_pins[k];
      for (int j = 0; j < NM; j++)
        if (e[j]) m_kio[j] = o[j];
        else if (io_drv[j]) m_kio[j] = io_ext[j];
    end
    if (req) begin
      if (!m_hold) begin m_so = o; m_soe = e; end
      m_hold = 1'b1;
      m_low = 0;
    end else if (m_hold) begin
      m_low++;
      if (m_low == EXIT_CYC) m_hold = 1'b0;
    end
    #2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cfg_tmask = {9'h120, 9'h088, 9'h010, 9'h003};
    cfg_cmask = {9'h000, 9'h001, 9'h004, 9'h000};
    cfg_oe_t  = {9'h000, 9'h000};
    cfg_oe_c  = {9'h018, 9'h000};
    cfg_reg   = 2'b11;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R3: registers clear, inversion on macrocell 0 only, both enables true
    n_chk++;
    if (mc_out !== 2'b01 || mc_oe !== 2'b11) begin
      n_fail++;
      $display("FAIL R3 reset: out=%b oe=%b expected out=01 oe=11", mc_out, mc_oe);
    end
    check("R3");

    // R1 R4: exhaustive combinational sweep, feature disabled
    cfg_reg = 2'b00; in_drv = '1; io_drv = '1;
    for (int v = 0; v < 128; v++) begin
      in_pins = v[3:0]; pd_pin = v[4]; io_ext = v[6:5];
      check("R1 R4 sweep");
      step();
    end
    pd_pin = 1'b0;

    // R5: pin cut from the array when enabled
    pd_en = 1'b1;
    for (int v = 0; v < 32; v++) begin
      in_pins = v[3:0]; io_ext = v[4:3]; pd_pin = 1'b1;
      check("R5 pd masked");
      pd_pin = 1'b0;
      #1;
      step();
    end

    // R2: registered outputs with feedback
    cfg_reg = 2'b11;
    for (int i = 0; i < 24; i++) begin
      in_pins = 4'((i*7+3) % 16); io_ext = 2'(i % 4);
      step();
      check("R2 registered");
    end

    // R6: freeze including a disabled output enable
    cfg_reg = 2'b01; in_pins = 4'b1011; io_ext = 2'b11;
    step();
    pd_pin = 1'b1;
    check("R6 pre-entry");
    step();
    for (int i = 0; i < 6; i++) begin
      in_pins = 4'(i*3); io_ext = 2'(~i); in_drv = 4'(i+9); io_drv = 2'(i);
      check("R6 held");
      step();
    end
    in_drv = '1; io_drv = '1;

    // R8: exit countdown, restart, then R7 state continuity
    pd_pin = 1'b0;
    step(); check("R8 held after 1 low edge");
    step(); check("R8 held after 2 low edges");
    step(); check("R8 R7 resumed after 3 low edges");
    pd_pin = 1'b1; step(); check("R8 re-entry");
    pd_pin = 1'b0; step(); check("R8 countdown 1");
    step(); check("R8 countdown 2");
    pd_pin = 1'b1; step(); check("R8 restart");
    pd_pin = 1'b0;
    step(); check("R8 after restart 1");
    step(); check("R8 after restart 2");
    step(); check("R8 R7 resumed after restart");
    step(); check("R7 registers continue");

    // R9: keepers
    cfg_reg = 2'b00; pd_en = 1'b0;
    in_drv = '1; in_pins = 4'b0011; io_drv = '1; io_ext = 2'b10;
    step();
    in_drv = '0; in_pins = 4'b1100; io_drv = '0; io_ext = 2'b01;
    check("R9 kept level");
    step(); check("R9 kept level after edge");
    pd_en = 1'b1; in_drv = '1; in_pins = 4'b0011;
    step();
    pd_pin = 1'b1; step();
    in_pins = 4'b1100;
    for (int i = 0; i < 3; i++) begin
      check("R9 R6 held drive");
      step();
    end
    pd_pin = 1'b0; in_drv = '0; in_pins = 4'b0000;
    for (int i = 0; i < 3; i++) step();
    check("R9 keeper unchanged by held drive");
    // R9: pre-hold keeper 0011 makes in0&in1 true, inverted to 0
    n_chk++;
    if (mc_out[0] !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 keeper: out0=%b expected 0", mc_out[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule